// File: doc/BRIEF.md
# Erase-Block Lock Manager

This block keeps one protection bit per erase block of a flash array and decides whether a given block may currently be erased or programmed. Software changes the bits with two-cycle write sequences on a 16-bit data bus. The first write arms the sequence. The second write either protects the single block that its address falls in, or removes protection from every block at once, whatever its address. The rest of the array controller presents a block index on the query port and refuses an erase or program whenever the block reports as locked.

The bits stand in for non-volatile cells. The functional reset (`rst_n`) only returns the sequence logic to idle. The bits are cleared only by an unlock-all sequence or by the simulation-only `sim_init` input, which models the factory-fresh, fully unlocked state. Every update starts a busy window of `BUSY_CYC` clock cycles. Lock writes that arrive during this window are dropped.

The sequencer has three states. IDLE waits for a setup write. A setup write (IDLE→ARMED) arms it. In ARMED, a lock confirm or an unlock-all confirm moves to HOLD (ARMED→HOLD). Any other data aborts the sequence (ARMED→IDLE) and raises the error flag. HOLD counts down the busy window and then returns to IDLE (HOLD→IDLE). Reset forces IDLE from any state.

Top module: `blk_lock_ctrl`

## Requirements
- R1: After `sim_init` has been high for one clock edge, every block reads unlocked. After `rst_n` is released, `busy` is 0 and `seq_err` is 0.
- R2: In IDLE, a write with data 16'h0060 arms the sequence. Only the write that immediately follows it is taken as a confirm.
- R3: An armed confirm with data 16'h0001 sets the lock bit of block `wr_addr >> BLK_SHIFT`, where the index comes from the confirm write's own address. The change is visible at the clock edge that takes the confirm, and all other bits keep their values.
- R4: An armed confirm with data 16'h00D0 clears every lock bit at that same edge, whatever the address.
- R5: An armed confirm with any other data changes no lock bit, returns to IDLE and sets `seq_err` from the next cycle. `seq_err` stays set until the next accepted setup write or a reset.
- R6: `busy` rises on the cycle after an accepted confirm and stays high for exactly `BUSY_CYC` cycles. Writes during that time neither arm the sequence nor change any bit.
- R7: `blk_locked` shows, combinationally, the lock bit of block `qry_blk`. A value of 1 means an erase or program of that block must be refused.
- R8: Asserting `rst_n` returns the sequencer to IDLE, which drops an armed sequence, but it leaves every lock bit as it was.
- R9: In IDLE, writes with any data other than 16'h0060, including 16'h0001 and 16'h00D0, change no lock bit and do not arm.
- R10: `sim_init` clears every lock bit at the next clock edge, even while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the sequencer only |
| sim_init | input | 1 | Simulation-only clear of all lock bits |
| wr_en | input | 1 | Command write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Command data of the write |
| qry_blk | input | IDX_W | Block index to query |
| blk_locked | output | 1 | Lock bit of the queried block |
| seq_err | output | 1 | Sticky flag for an aborted sequence |
| busy | output | 1 | High while an update is completing |

## Verification
The hardest case to reach is a setup write that lands inside the busy window and is followed by a lock confirm after the window closes. A faulty design would leave the sequence armed and lock a block. The bench issues a setup write on the first cycle after a confirm, waits for `busy` to fall, sends a lock confirm and checks that no bit moved. A second hard case is a reset that arrives while the sequence is armed. The bench pulses `rst_n` between a setup and a confirm, then shows through the query port that the bits survived and that the confirm is ignored.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

    localparam logic [15:0] CMD_ARM      = 16'h0060;
    localparam logic [15:0] CMD_LOCK_ONE = 16'h0001;
    localparam logic [15:0] CMD_FREE_ALL = 16'h00D0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_HOLD
    } lk_state_t;

    typedef enum logic [1:0] {
        OP_OTHER,
        OP_ARM,
        OP_LOCK_ONE,
        OP_FREE_ALL
    } lk_op_t;

endpackage

// File: rtl/lk_cmd_decode.sv
module lk_cmd_decode
    import blk_lock_pkg::*;
(
    input  logic [15:0] data,
    output lk_op_t      op
);
    always_comb begin
        unique case (data)
            CMD_ARM:      op = OP_ARM;
            CMD_LOCK_ONE: op = OP_LOCK_ONE;
            CMD_FREE_ALL: op = OP_FREE_ALL;
            default:      op = OP_OTHER;
        endcase
    end
endmodule

// File: rtl/lk_seq_fsm.sv
module lk_seq_fsm
    import blk_lock_pkg::*;
#(
    parameter int BUSY_CYC = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  lk_op_t op,
    output logic   set_req,
    output logic   clr_req,
    output logic   seq_err,
    output logic   busy
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    lk_state_t        state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             err_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            seq_err <= 1'b0;
        end else begin
            state   <= state_nx;
            cnt     <= cnt_nx;
            seq_err <= err_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        err_nx   = seq_err;
        set_req  = 1'b0;
        clr_req  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (wr_en && op == OP_ARM) begin
                    state_nx = ST_ARMED;
                    err_nx   = 1'b0;
                end
            end
            ST_ARMED: begin
                if (wr_en) begin
                    if (op == OP_LOCK_ONE || op == OP_FREE_ALL) begin
                        set_req  = (op == OP_LOCK_ONE);
                        clr_req  = (op == OP_FREE_ALL);
                        state_nx = ST_HOLD;
                        cnt_nx   = CNT_W'(BUSY_CYC - 1);
                    end else begin
                        state_nx = ST_IDLE;
                        err_nx   = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (cnt == '0) state_nx = ST_IDLE;
                else           cnt_nx   = cnt - 1'b1;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign busy = (state == ST_HOLD);

    a_r2_setup_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_en && op == OP_ARM) |=> (state == ST_ARMED && !seq_err));
    a_r5_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && wr_en && (op == OP_OTHER || op == OP_ARM))
            |=> (seq_err && state == ST_IDLE));
    a_r6_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < CNT_W'(BUSY_CYC)));
    a_r6_enter_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req || clr_req) |=> busy);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ARMED) |-> !(set_req || clr_req));
endmodule

// File: rtl/lk_bank.sv
module lk_bank #(
    parameter int NUM_BLOCKS = 8,
    localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_all,
    input  logic [IDX_W-1:0] qry_idx,
    output logic             locked
);
    logic [NUM_BLOCKS-1:0] bits;

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (init || clr_all)
                bits[i] <= 1'b0;
            else if (set_en && set_idx == IDX_W'(i))
                bits[i] <= 1'b1;
        end

        a_r3_sets_cell: assert property (@(posedge clk) disable iff (!rst_n)
            (set_en && !init && set_idx == IDX_W'(i)) |=> bits[i]);
    end

    assign locked = (int'(qry_idx) < NUM_BLOCKS) ? bits[qry_idx] : 1'b0;

    a_r4_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (bits == '0));
    a_r10_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (bits == '0));
    a_r5_holds_value: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_all && !init) |=> $stable(bits));
endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
    import blk_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int BLK_SHIFT  = 10,
    parameter int BUSY_CYC   = 4,
    parameter int IDX_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    parameter int ADDR_W     = BLK_SHIFT + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sim_init,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [IDX_W-1:0]  qry_blk,
    output logic              blk_locked,
    output logic              seq_err,
    output logic              busy
);
    lk_op_t           op;
    logic             set_req, clr_req;
    logic [IDX_W-1:0] tgt_idx;

    assign tgt_idx = IDX_W'(wr_addr >> BLK_SHIFT);

    lk_cmd_decode u_dec (
        .data (wr_data),
        .op   (op)
    );

    lk_seq_fsm #(.BUSY_CYC(BUSY_CYC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .op      (op),
        .set_req (set_req),
        .clr_req (clr_req),
        .seq_err (seq_err),
        .busy    (busy)
    );

    lk_bank #(.NUM_BLOCKS(NUM_BLOCKS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (sim_init),
        .set_en  (set_req),
        .set_idx (tgt_idx),
        .clr_all (clr_req),
        .qry_idx (qry_blk),
        .locked  (blk_locked)
    );
endmodule

// File: tb/sim_blk_lock_ctrl.sv
`timescale 1ns/1ps
module sim_blk_lock_ctrl;
    localparam int NB    = 8;
    localparam int SH    = 10;
    localparam int BC    = 4;
    localparam int IW    = 3;
    localparam int AW    = SH + IW;

    typedef struct {
        string       req;
        logic [NB-1:0] mask;
        logic        err;
        logic        bsy;
    } exp_t;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          sim_init = 0;
    logic          wr_en = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [IW-1:0] qry_blk = '0;
    logic          blk_locked, seq_err, busy;

    int vectors = 0, errors = 0, pushed = 0, popped = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    blk_lock_ctrl #(.NUM_BLOCKS(NB), .BLK_SHIFT(SH), .BUSY_CYC(BC)) u0 (
        .clk, .rst_n, .sim_init, .wr_en, .wr_addr, .wr_data,
        .qry_blk, .blk_locked, .seq_err, .busy
    );

    function automatic logic [AW-1:0] adr(input int blk, input int off);
        return AW'((blk << SH) | off);
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic expect_state(input string req, input logic [NB-1:0] m,
                                input logic e, input logic b);
        exp_t it;
        it.req = req; it.mask = m; it.err = e; it.bsy = b;
        q.push_back(it);
        pushed++;
        wait (popped == pushed);
    endtask

    task automatic count_busy(input string req);
        int n = 0;
        while (busy) begin n++; @(negedge clk); end
        vectors++;
        if (n != BC) begin
            errors++;
            $display("FAIL %s busy length actual=%0d expected=%0d", req, n, BC);
        end
    endtask

    // monitor: sweeps the query port and compares against the queued snapshot
    initial begin
        forever begin
            exp_t it;
            logic [NB-1:0] got;
            wait (q.size() > 0);
            it = q.pop_front();
            for (int b = 0; b < NB; b++) begin
                qry_blk = IW'(b);
                #0.2;
                got[b] = blk_locked;
            end
            vectors++;
            if (got !== it.mask || seq_err !== it.err || busy !== it.bsy) begin
                errors++;
                $display("FAIL %s actual mask=%h err=%b busy=%b expected mask=%h err=%b busy=%b",
                         it.req, got, seq_err, busy, it.mask, it.err, it.bsy);
            end
            popped++;
        end
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R1 / R10: factory state during reset
        sim_init = 1;
        repeat (2) @(negedge clk);
        sim_init = 0;
        rst_n = 1;
        @(negedge clk);
        expect_state("R1 initial", 8'h00, 0, 0);

        // R2 / R3: setup in block 5, confirm in block 3 locks block 3
        wr(adr(5, 7), 16'h0060);
        wr(adr(3, 'h77), 16'h0001);
        expect_state("R3 lock blk3", 8'h08, 0, 1);
        count_busy("R6");
        expect_state("R6 busy cleared", 8'h08, 0, 0);

        // R3 boundaries: first and last block
        wr(adr(0, 0), 16'h0060); wr(adr(0, 0), 16'h0001);
        count_busy("R6");
        wr(adr(7, 0), 16'h0060); wr(adr(7, 1023), 16'h0001);
        count_busy("R6");
        expect_state("R3 blk0 and blk7", 8'h89, 0, 0);

        // R9: confirm codes in IDLE are ignored
        wr(adr(2, 0), 16'h0001);
        wr(adr(2, 0), 16'h00D0);
        wr(adr(2, 0), 16'h0001);
        expect_state("R9 idle ignores", 8'h89, 0, 0);

        // R5: bad confirm
        wr(adr(1, 0), 16'h0060);
        wr(adr(1, 0), 16'h1234);
        expect_state("R5 abort", 8'h89, 1, 0);
        wr(adr(1, 0), 16'h0001);
        expect_state("R5 abort leaves idle", 8'h89, 1, 0);
        wr(adr(1, 0), 16'h0060);
        expect_state("R5 err cleared by setup", 8'h89, 0, 0);
        wr(adr(1, 4), 16'h0001);
        expect_state("R2 armed confirm locks blk1", 8'h8B, 0, 1);

        // R6: setup during busy is dropped
        wr(adr(4, 0), 16'h0060);
        wait (!busy);
        wr(adr(4, 0), 16'h0001);
        expect_state("R6 write during busy ignored", 8'h8B, 0, 0);

        // R5: setup as confirm counts as bad data
        wr(adr(4, 0), 16'h0060);
        wr(adr(4, 0), 16'h0060);
        expect_state("R5 setup as confirm", 8'h8B, 1, 0);

        // R8: reset while armed keeps bits and drops the arm
        wr(adr(4, 0), 16'h0060);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        expect_state("R8 locks kept through reset", 8'h8B, 0, 0);
        wr(adr(4, 0), 16'h0001);
        expect_state("R8 arm dropped", 8'h8B, 0, 0);

        // R4: unlock all from an unrelated address
        wr(adr(6, 3), 16'h0060);
        wr(adr(6, 99), 16'h00D0);
        expect_state("R4 clear all", 8'h00, 0, 1);
        count_busy("R6");

        // R7: single lock visible only at its index
        wr(adr(2, 0), 16'h0060); wr(adr(2, 0), 16'h0001);
        count_busy("R6");
        expect_state("R7 query blk2 only", 8'h04, 0, 0);

        // R10: simulation clear
        @(negedge clk); sim_init = 1;
        @(negedge clk); sim_init = 0;
        expect_state("R10 init clears", 8'h00, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule